// File: doc/BRIEF.md
# Adaptive JTAG Clock Generator

This block produces the test clock for a JTAG probe from a fast system clock. A TAP engine holds `shift_req` high for as long as it has bits to move. The generator then runs one test-clock period per bit. It marks each period with single-cycle strobes: `sample_stb` when the clock rises (capture TDO), `update_stb` when it falls (present new TMS/TDI), and `shift_done` when the low half ends and the bit is complete.

A 4-bit rate code picks the pacing. Code 0 selects adaptive pacing. In that mode every edge is handed to the target, and the generator waits until the returned clock, after a two-flop synchronizer, has followed it. Only then does it issue the next edge. A slow-core flag adds settling cycles before a returned edge is accepted. A programmable timeout reports a target that never answers. All other codes give fixed divided rates.

The code may change while the clock runs. The new rate is picked up only when a period starts from the low level, so no shortened high pulse can occur.

Top module: `tck_pacer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `tck` is low and `sample_stb`, `update_stb`, `shift_done` and `timeout_err` are low.
- R2: With the default `SYS_HZ` of 64 MHz, codes 1 to 10 give half-periods of 2, 4, 8, 32, 64, 160, 320, 640, 1600 and 3200 system cycles (16 MHz down to 10 kHz). `tck` stays high for exactly one half-period.
- R3: Codes 11 to 15 behave exactly like code 10 (half-period 3200).
- R4: The rate code is sampled only when a period starts from `tck` low. A code change made during a high phase leaves the current period untouched and applies from the next one.
- R5: `sample_stb` is high for one cycle, in the cycle `tck` becomes high. `update_stb` is high for one cycle, in the cycle `tck` becomes low. `shift_done` is high for one cycle when a low phase completes.
- R6: With `shift_req` low and the clock idle, `tck` stays low and no strobe fires.
- R7: With code 0, after a rising edge `tck` does not fall until the synchronized `rtck_in` is high. After a falling edge it does not rise again until the synchronized `rtck_in` is low. With a one-cycle echo each phase lasts 3 cycles.
- R8: With code 0 and `slow_core` high, a returned level must be held for `SLOW_SETTLE` (default 3) further cycles before it is accepted. With a one-cycle echo each phase lasts 6 cycles.
- R9: In adaptive mode a non-zero `timeout_lim` of N makes `timeout_err` pulse once, N cycles after the edge whose answer is missing. The clock keeps waiting. A limit of 0 disables the pulse.
- R10: With `shift_req` held high, a new period starts in the cycle the previous low phase ends. A fixed rate then has a low phase equal to its half-period and no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 4 | Rate code: 0 adaptive, 1-10 fixed, 11-15 slowest fixed |
| slow_core | input | 1 | Adds settling cycles to returned-clock acceptance |
| timeout_lim | input | TO_W | Adaptive wait limit in cycles, 0 disables |
| shift_req | input | 1 | TAP engine requests clock periods |
| rtck_in | input | 1 | Returned clock from the target, asynchronous |
| tck | output | 1 | Test clock to the target |
| sample_stb | output | 1 | One-cycle pulse at the rising edge of `tck` |
| update_stb | output | 1 | One-cycle pulse at the falling edge of `tck` |
| shift_done | output | 1 | One-cycle pulse when a full period completes |
| timeout_err | output | 1 | One-cycle pulse when the adaptive wait exceeds the limit |

## Verification
The adaptive properties assume the target only moves its returned clock in answer to a `tck` edge. In particular, the returned clock is low whenever the generator goes idle after an adaptive period. The bench echo model keeps within this: it copies `tck` into `rtck_in` one cycle later, or holds it frozen. It never toggles the returned clock on its own. Rate codes are changed only while `tck` is high or the clock is idle.

// File: rtl/tckgen_pkg.sv
`timescale 1ns/1ps
package tckgen_pkg;
    localparam int HALF_W = 16;
    localparam int STAB_W = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HIGH,
        PH_LOW,
        PH_WAIT_HI,
        PH_WAIT_LO
    } phase_e;

    typedef struct packed {
        logic              adaptive;
        logic [HALF_W-1:0] half;
    } rate_s;

    // Frequency in Hz for a rate code; unused codes map to the slowest rate.
    function automatic int unsigned fixed_hz(input int unsigned code);
        case (code)
            1:       return 16_000_000;
            2:       return 8_000_000;
            3:       return 4_000_000;
            4:       return 1_000_000;
            5:       return 500_000;
            6:       return 200_000;
            7:       return 100_000;
            8:       return 50_000;
            9:       return 20_000;
            default: return 10_000;
        endcase
    endfunction

    function automatic int unsigned half_cycles(input int unsigned code,
                                                input int unsigned sys_hz);
        int unsigned h;
        h = sys_hz / (2 * fixed_hz(code));
        return (h == 0) ? 1 : h;
    endfunction
endpackage

// File: rtl/tck_rate_select.sv
`timescale 1ns/1ps
module tck_rate_select
    import tckgen_pkg::*;
#(
    parameter int unsigned SYS_HZ = 64_000_000
) (
    input  logic [3:0] code,
    output rate_s      rate
);
    localparam int NCODES = 16;

    logic [HALF_W-1:0] table_q [NCODES];

    for (genvar g = 0; g < NCODES; g++) begin : g_rate
        localparam logic [HALF_W-1:0] HALF_G = HALF_W'(half_cycles(g, SYS_HZ));
        assign table_q[g] = HALF_G;
    end

    always_comb begin
        rate.adaptive = (code == 4'd0);
        rate.half     = table_q[code];
    end
endmodule

// File: rtl/rtck_sync.sv
`timescale 1ns/1ps
module rtck_sync
    import tckgen_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rtck_in,
    input  logic              tck_lvl,
    output logic              rtck_s,
    output logic [STAB_W-1:0] stab_cnt
);
    localparam logic [STAB_W-1:0] STAB_MAX = '1;

    logic [STAGES-1:0] chain;

    assign rtck_s = chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            chain    <= '0;
            stab_cnt <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], rtck_in};
            if (rtck_s == tck_lvl)
                stab_cnt <= (stab_cnt == STAB_MAX) ? stab_cnt : stab_cnt + 1'b1;
            else
                stab_cnt <= '0;
        end
    end
endmodule

// File: rtl/tck_phase_fsm.sv
`timescale 1ns/1ps
module tck_phase_fsm
    import tckgen_pkg::*;
#(
    parameter int SLOW_SETTLE = 3,
    parameter int TO_W        = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  rate_s             rate,
    input  logic              shift_req,
    input  logic              slow_core,
    input  logic [TO_W-1:0]   timeout_lim,
    input  logic              rtck_s,
    input  logic [STAB_W-1:0] stab_cnt,
    output logic              tck,
    output logic              sample_stb,
    output logic              update_stb,
    output logic              shift_done,
    output logic              timeout_err,
    output rate_s             cur_rate
);
    localparam logic [TO_W-1:0]   WAIT_MAX  = '1;
    localparam logic [STAB_W-1:0] SETTLE_SL = STAB_W'(SLOW_SETTLE);

    phase_e            st, st_n;
    logic [HALF_W-1:0] cnt, cnt_n;
    logic [TO_W-1:0]   wcnt, wcnt_n;
    rate_s             cur_n;
    logic              tck_n, smp_n, upd_n, done_n, err_n;
    logic              rise, waiting, accept;
    logic [STAB_W-1:0] need;

    always_comb begin
        need   = slow_core ? SETTLE_SL : '0;
        accept = (rtck_s == tck) && (stab_cnt >= need);
    end

    always_comb begin
        st_n    = st;
        tck_n   = tck;
        cnt_n   = cnt;
        wcnt_n  = wcnt;
        cur_n   = cur_rate;
        smp_n   = 1'b0;
        upd_n   = 1'b0;
        done_n  = 1'b0;
        err_n   = 1'b0;
        rise    = 1'b0;
        waiting = 1'b0;
        case (st)
            PH_IDLE: rise = shift_req;
            PH_HIGH: begin
                if (cnt == '0) begin
                    tck_n = 1'b0;
                    upd_n = 1'b1;
                    st_n  = PH_LOW;
                    cnt_n = cur_rate.half - 1'b1;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            PH_LOW: begin
                if (cnt == '0) begin
                    done_n = 1'b1;
                    rise   = shift_req;
                    if (!shift_req) st_n = PH_IDLE;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            PH_WAIT_HI: begin
                if (accept) begin
                    tck_n  = 1'b0;
                    upd_n  = 1'b1;
                    st_n   = PH_WAIT_LO;
                    wcnt_n = '0;
                end else begin
                    waiting = 1'b1;
                end
            end
            PH_WAIT_LO: begin
                if (accept) begin
                    done_n = 1'b1;
                    rise   = shift_req;
                    if (!shift_req) st_n = PH_IDLE;
                end else begin
                    waiting = 1'b1;
                end
            end
            default: st_n = PH_IDLE;
        endcase

        if (waiting) begin
            wcnt_n = (wcnt == WAIT_MAX) ? wcnt : wcnt + 1'b1;
            err_n  = (timeout_lim != '0) &&
                     (({1'b0, wcnt} + 1'b1) == {1'b0, timeout_lim});
        end

        // A period may only start here, with tck low: the rate is latched now.
        if (rise) begin
            tck_n  = 1'b1;
            smp_n  = 1'b1;
            cur_n  = rate;
            cnt_n  = rate.half - 1'b1;
            wcnt_n = '0;
            st_n   = rate.adaptive ? PH_WAIT_HI : PH_HIGH;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= PH_IDLE;
            tck         <= 1'b0;
            cnt         <= '0;
            wcnt        <= '0;
            cur_rate    <= '0;
            sample_stb  <= 1'b0;
            update_stb  <= 1'b0;
            shift_done  <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            st          <= st_n;
            tck         <= tck_n;
            cnt         <= cnt_n;
            wcnt        <= wcnt_n;
            cur_rate    <= cur_n;
            sample_stb  <= smp_n;
            update_stb  <= upd_n;
            shift_done  <= done_n;
            timeout_err <= err_n;
        end
    end
endmodule

// File: rtl/tck_pacer.sv
`timescale 1ns/1ps
module tck_pacer
    import tckgen_pkg::*;
#(
    parameter int unsigned SYS_HZ      = 64_000_000,
    parameter int          SYNC_STAGES = 2,
    parameter int          SLOW_SETTLE = 3,
    parameter int          TO_W        = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [3:0]      rate_sel,
    input  logic            slow_core,
    input  logic [TO_W-1:0] timeout_lim,
    input  logic            shift_req,
    input  logic            rtck_in,
    output logic            tck,
    output logic            sample_stb,
    output logic            update_stb,
    output logic            shift_done,
    output logic            timeout_err
);
    rate_s             sel_rate;
    rate_s             cur_rate;
    logic              rtck_s;
    logic [STAB_W-1:0] stab_cnt;

    tck_rate_select #(.SYS_HZ(SYS_HZ)) u_rate (
        .code (rate_sel),
        .rate (sel_rate)
    );

    rtck_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .rtck_in  (rtck_in),
        .tck_lvl  (tck),
        .rtck_s   (rtck_s),
        .stab_cnt (stab_cnt)
    );

    tck_phase_fsm #(.SLOW_SETTLE(SLOW_SETTLE), .TO_W(TO_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .rate        (sel_rate),
        .shift_req   (shift_req),
        .slow_core   (slow_core),
        .timeout_lim (timeout_lim),
        .rtck_s      (rtck_s),
        .stab_cnt    (stab_cnt),
        .tck         (tck),
        .sample_stb  (sample_stb),
        .update_stb  (update_stb),
        .shift_done  (shift_done),
        .timeout_err (timeout_err),
        .cur_rate    (cur_rate)
    );
endmodule

// File: rtl/tck_pacer_sva.sv
`timescale 1ns/1ps
module tck_pacer_sva
    import tckgen_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tck,
    input logic              sample_stb,
    input logic              update_stb,
    input logic              shift_done,
    input logic              timeout_err,
    input logic              shift_req,
    input logic              rtck_s,
    input logic              adaptive_q,
    input logic [HALF_W-1:0] half_q
);
    // R5: capture strobe only alongside a rising edge
    a_r5_sample_on_rise: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> $rose(tck));

    // R5: update strobe only alongside a falling edge
    a_r5_update_on_fall: assert property (@(posedge clk) disable iff (rst)
        update_stb |-> $fell(tck));

    // R5: a completed bit is never reported while the clock is high
    a_r5_done_low: assert property (@(posedge clk) disable iff (rst)
        shift_done && !sample_stb |-> !tck);

    // R6: a rising edge needs a request
    a_r6_rise_needs_req: assert property (@(posedge clk) disable iff (rst)
        $rose(tck) |-> $past(shift_req));

    // R4: the active rate stays fixed through a high phase
    a_r4_rate_hold_high: assert property (@(posedge clk) disable iff (rst)
        tck && $past(tck) |-> $stable(half_q));

    // R7: adaptive fall only after the returned clock is high
    a_r7_fall_after_rtck: assert property (@(posedge clk) disable iff (rst)
        $fell(tck) && adaptive_q |-> $past(rtck_s));

    // R7: adaptive rise only after the returned clock is low
    a_r7_rise_after_rtck: assert property (@(posedge clk) disable iff (rst)
        $rose(tck) && adaptive_q && $past(adaptive_q) |-> !$past(rtck_s));

    // R9: the timeout flag is a single-cycle pulse
    a_r9_err_pulse: assert property (@(posedge clk) disable iff (rst)
        timeout_err |=> !timeout_err);
endmodule

bind tck_pacer tck_pacer_sva u_sva (
    .clk         (clk),
    .rst         (rst),
    .tck         (tck),
    .sample_stb  (sample_stb),
    .update_stb  (update_stb),
    .shift_done  (shift_done),
    .timeout_err (timeout_err),
    .shift_req   (shift_req),
    .rtck_s      (rtck_s),
    .adaptive_q  (cur_rate.adaptive),
    .half_q      (cur_rate.half)
);

// File: tb/tck_pacer_tb.sv
`timescale 1ns/1ps
module tck_pacer_tb;
    localparam int TO_W = 16;
    localparam int NVEC = 12;
    // {rate code, expected half-period in cycles}
    localparam int VEC [NVEC][2] = '{
        '{1, 2}, '{2, 4}, '{3, 8}, '{4, 32}, '{5, 64}, '{6, 160},
        '{7, 320}, '{8, 640}, '{9, 1600}, '{10, 3200}, '{11, 3200}, '{15, 3200}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [3:0]      rate_sel = 4'd1;
    logic            slow_core = 1'b0;
    logic [TO_W-1:0] timeout_lim = '0;
    logic            shift_req = 1'b0;
    logic            rtck_in = 1'b0;
    logic            echo_en = 1'b1;
    logic            tck, sample_stb, update_stb, shift_done, timeout_err;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    tck_pacer #(.TO_W(TO_W)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .rate_sel    (rate_sel),
        .slow_core   (slow_core),
        .timeout_lim (timeout_lim),
        .shift_req   (shift_req),
        .rtck_in     (rtck_in),
        .tck         (tck),
        .sample_stb  (sample_stb),
        .update_stb  (update_stb),
        .shift_done  (shift_done),
        .timeout_err (timeout_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Target model: returned clock follows tck one cycle later when enabled
    initial forever begin
        @(negedge clk);
        if (echo_en) rtck_in = tck;
    end

    // R5 strobe monitor
    initial begin
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (sample_stb || (tck && !prev))
                    chk("R5 sample_stb at rise", int'(sample_stb), int'(tck && !prev));
                if (update_stb || (!tck && prev))
                    chk("R5 update_stb at fall", int'(update_stb), int'(!tck && prev));
            end
            prev = tck;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    task automatic wait_done();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (shift_done !== 1'b1 && guard < 20000);
        repeat (3) @(negedge clk);
    endtask

    // Counts one high phase and the following low phase; request must be held.
    task automatic measure(output int hi, output int lo);
        hi = 0;
        lo = 0;
        do @(negedge clk); while (tck !== 1'b1);
        while (tck === 1'b1) begin hi++; @(negedge clk); end
        while (tck === 1'b0) begin lo++; @(negedge clk); end
    endtask

    initial begin
        int hi, lo, k, errs, highs;
        repeat (4) @(negedge clk);
        chk("R1 tck in reset", int'(tck), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 tck after reset", int'(tck), 0);
        chk("R1 strobes after reset",
            int'(sample_stb) + int'(update_stb) + int'(shift_done), 0);
        chk("R1 timeout_err after reset", int'(timeout_err), 0);

        // R6: no request, no clock
        highs = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            highs += int'(tck) + int'(sample_stb) + int'(shift_done);
        end
        chk("R6 idle without request", highs, 0);

        // R2 / R3 / R10: walk the rate table
        for (int v = 0; v < NVEC; v++) begin
            rate_sel  = 4'(VEC[v][0]);
            shift_req = 1'b1;
            measure(hi, lo);
            shift_req = 1'b0;
            chk((VEC[v][0] > 10) ? "R3 high phase" : "R2 high phase", hi, VEC[v][1]);
            chk("R10 back-to-back low phase", lo, VEC[v][1]);
            wait_done();
        end

        // R4: rate change during a high phase applies from the next period
        rate_sel  = 4'd1;
        shift_req = 1'b1;
        do @(negedge clk); while (tck !== 1'b1);
        rate_sel = 4'd2;
        hi = 0;
        lo = 0;
        while (tck === 1'b1) begin hi++; @(negedge clk); end
        while (tck === 1'b0) begin lo++; @(negedge clk); end
        chk("R4 current high keeps old rate", hi, 2);
        chk("R4 current low keeps old rate", lo, 2);
        k = 0;
        while (tck === 1'b1) begin k++; @(negedge clk); end
        chk("R4 next high uses new rate", k, 4);
        shift_req = 1'b0;
        wait_done();

        // R7: adaptive pacing with a one-cycle echo
        rate_sel  = 4'd0;
        slow_core = 1'b0;
        shift_req = 1'b1;
        measure(hi, lo);
        shift_req = 1'b0;
        chk("R7 adaptive high phase", hi, 3);
        chk("R7 adaptive low phase", lo, 3);
        wait_done();

        // R8: slow-core settling
        slow_core = 1'b1;
        shift_req = 1'b1;
        measure(hi, lo);
        shift_req = 1'b0;
        chk("R8 slow-core high phase", hi, 6);
        chk("R8 slow-core low phase", lo, 6);
        wait_done();
        slow_core = 1'b0;

        // R9 / R7: silent target with a timeout of 20 cycles
        echo_en     = 1'b0;
        timeout_lim = 16'd20;
        shift_req   = 1'b1;
        do @(negedge clk); while (tck !== 1'b1);
        k = 0;
        while (timeout_err !== 1'b1 && k < 100) begin k++; @(negedge clk); end
        chk("R9 timeout after limit", k, 20);
        errs  = 0;
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            errs  += int'(timeout_err);
            highs += int'(tck);
        end
        chk("R9 single timeout pulse", errs, 0);
        chk("R7 no edge without returned clock", highs, 40);
        shift_req = 1'b0;
        echo_en   = 1'b1;
        wait_done();
        chk("R7 clock resumes after return", int'(tck), 0);

        // R9: zero limit disables the flag
        echo_en     = 1'b0;
        timeout_lim = '0;
        shift_req   = 1'b1;
        errs = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            errs += int'(timeout_err);
        end
        chk("R9 zero limit never flags", errs, 0);
        shift_req = 1'b0;
        echo_en   = 1'b1;
        wait_done();

        finish_run();
    end
endmodule